// File: doc/BRIEF.md
# Block-Scaled FP4 Dot-Product Unit

This unit takes two blocks of 32 four-bit E2M1 floating-point operands and multiplies them pairwise. It forms the exact sum of the 32 products and scales that sum by two shared power-of-two factors, one for each side. The result is returned as an IEEE-754 single-precision word. It serves as the reduction step of a microscaled matrix engine: a caller packs 32 byte containers per side into eight 32-bit words, supplies one exponent byte per side, pulses start and collects the result when done pulses.

Internally every element is decoded to a small signed integer in half units, so each product is an exact integer in quarter units. The 32-term sum is kept exactly in a narrow signed register. Conversion to single precision is then a leading-one search and a shift, and both scales enter only as additions to the exponent. No rounding step exists, because every reachable sum fits in the 24-bit significand.

Top module: `fp4_blk_dot`

## Requirements
- R1: Each element is the 8-bit container's bits 5-2 taken as a nibble. Nibble bit 3 is the sign, and nibble bits 2-0 select the magnitudes 0, 0.5, 1, 1.5, 2, 3, 4 and 6 for codes 0 to 7. Container bits 7-6 and 1-0 have no effect on the result.
- R2: Element 4w+j of a side is byte j (bits 8j+7..8j) of word w, and word w sits at bits 32w+31..32w of the 256-bit operand bus. Only A and B elements with the same index are multiplied together.
- R3: For a normal in-range result, `result_o` equals the exact value of the sum of the 32 products, multiplied by both scales, encoded without rounding.
- R4: Scale byte s on either side multiplies the result by 2^(s-127), so 0x7F is a scale of 1.0.
- R5: A sum of exactly zero gives +0.0 (0x00000000), including a sum of negative-zero elements.
- R6: A result at or above 2^128 in magnitude gives infinity of the sum's sign (exponent field 0xFF, zero fraction). A NaN is never produced.
- R7: A nonzero result below 2^-126 in magnitude flushes to +0.0. Subnormal encodings are never produced.
- R8: A start pulse while idle samples all inputs at that edge. Busy is then high for exactly two cycles. Done is high for one cycle, starting with the cycle in which busy falls, and result_o changes only at that edge and holds until the next done.
- R9: A start pulse while busy is ignored. The running operation's result and its single done pulse are unchanged.
- R10: After reset, busy_o and done_o are low and result_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| a_words_i | input | 256 | A containers, eight packed words |
| b_words_i | input | 256 | B containers, eight packed words |
| scale_a_i | input | 8 | A side exponent byte |
| scale_b_i | input | 8 | B side exponent byte |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | 32 | Single-precision result |

## Verification
On every cycle the assertions check the handshake shape: done lasts one cycle and coincides with busy falling, busy lasts two cycles, and result_o moves only with done. They also check the output encoding on every cycle: no NaN and no subnormal ever appear. The arithmetic itself can only be shown by the bench's scenarios. These cover decoding of each nibble code, ignored padding bits, element packing order, the two scales, exact zero, the edges of the normal and overflow ranges, and a start issued while busy.

// File: rtl/fp4_dot_pkg.sv
package fp4_dot_pkg;
  localparam int ELEMS   = 32;
  localparam int CONT_W  = 8;
  localparam int BUS_W   = ELEMS * CONT_W;
  localparam int HALF_W  = 5;                 // decoded element, units of 0.5
  localparam int PROD_W  = 2 * HALF_W;        // product, units of 0.25
  localparam int SUM_W   = $clog2(ELEMS * 144) + 2;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int EBIAS   = 127;

  typedef enum logic [1:0] {ST_IDLE, ST_SUM, ST_CONV} dot_state_e;
endpackage

// File: rtl/fp4_decode.sv
module fp4_decode
  import fp4_dot_pkg::*;
(
  input  logic [CONT_W-1:0]        cont_i,
  output logic signed [HALF_W-1:0] half_o
);
  logic [3:0]        nib;
  logic [HALF_W-1:0] mag;

  assign nib = cont_i[5:2];

  always_comb begin
    unique case (nib[2:0])
      3'd0: mag = 5'd0;
      3'd1: mag = 5'd1;
      3'd2: mag = 5'd2;
      3'd3: mag = 5'd3;
      3'd4: mag = 5'd4;
      3'd5: mag = 5'd6;
      3'd6: mag = 5'd8;
      default: mag = 5'd12;
    endcase
  end

  assign half_o = nib[3] ? -$signed(mag) : $signed(mag);
endmodule

// File: rtl/fp4_dot_tree.sv
module fp4_dot_tree
  import fp4_dot_pkg::*;
#(
  parameter int N   = ELEMS,
  parameter int SW  = SUM_W
) (
  input  logic [N*CONT_W-1:0]  a_i,
  input  logic [N*CONT_W-1:0]  b_i,
  output logic signed [SW-1:0] sum_o
);
  logic signed [PROD_W-1:0] prod [N];

  for (genvar g = 0; g < N; g++) begin : g_elem
    logic signed [HALF_W-1:0] ha, hb;
    fp4_decode u_dec_a (.cont_i(a_i[g*CONT_W +: CONT_W]), .half_o(ha));
    fp4_decode u_dec_b (.cont_i(b_i[g*CONT_W +: CONT_W]), .half_o(hb));
    assign prod[g] = PROD_W'(ha * hb);
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) sum_o = sum_o + SW'(prod[i]);
  end
endmodule

// File: rtl/fp4_to_fp32.sv
module fp4_to_fp32
  import fp4_dot_pkg::*;
#(
  parameter int SW = SUM_W
) (
  input  logic signed [SW-1:0] sum_i,   // units of 0.25
  input  logic [EXP_W-1:0]     sa_i,
  input  logic [EXP_W-1:0]     sb_i,
  output logic [31:0]          fp_o
);
  localparam int PW = $clog2(SW) + 1;
  localparam int EW = 12;

  logic              sgn;
  logic [SW-1:0]     mag;
  logic [PW-1:0]     pos;
  logic [SW+FRAC_W-1:0] shf;
  logic signed [EW-1:0] ebias;

  assign sgn = sum_i[SW-1];
  assign mag = sgn ? SW'(-sum_i) : SW'(sum_i);

  always_comb begin
    pos = '0;
    for (int i = 0; i < SW; i++) if (mag[i]) pos = PW'(i);
  end

  // leading one lands on bit FRAC_W; shift is lossless
  assign shf = {mag, {FRAC_W{1'b0}}} >> pos;
  // biased exponent = pos - 2 (quarter units) + (sa-127) + (sb-127) + 127
  assign ebias = $signed(EW'(pos)) + $signed(EW'(sa_i)) + $signed(EW'(sb_i))
               - $signed(EW'(2 + EBIAS));

  always_comb begin
    if (mag == '0)               fp_o = 32'h0;
    else if (ebias >= 12'sd255)  fp_o = {sgn, 8'hFF, 23'h0};
    else if (ebias <= 12'sd0)    fp_o = 32'h0;
    else                         fp_o = {sgn, ebias[7:0], shf[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fp4_blk_dot.sv
module fp4_blk_dot
  import fp4_dot_pkg::*;
#(
  parameter int N = ELEMS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [N*CONT_W-1:0] a_words_i,
  input  logic [N*CONT_W-1:0] b_words_i,
  input  logic [EXP_W-1:0]    scale_a_i,
  input  logic [EXP_W-1:0]    scale_b_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [31:0]         result_o
);
  localparam int SW = $clog2(N * 144) + 2;

  dot_state_e          st_q;
  logic [N*CONT_W-1:0] a_q, b_q;
  logic [EXP_W-1:0]    sa_q, sb_q;
  logic signed [SW-1:0] sum_d, sum_q;
  logic [31:0]         fp_d, res_q;
  logic                done_q;

  fp4_dot_tree #(.N(N), .SW(SW)) u_tree (
    .a_i(a_q), .b_i(b_q), .sum_o(sum_d)
  );

  fp4_to_fp32 #(.SW(SW)) u_conv (
    .sum_i(sum_q), .sa_i(sa_q), .sb_i(sb_q), .fp_o(fp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      a_q    <= '0;
      b_q    <= '0;
      sa_q   <= '0;
      sb_q   <= '0;
      sum_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          a_q  <= a_words_i;
          b_q  <= b_words_i;
          sa_q <= scale_a_i;
          sb_q <= scale_b_i;
          st_q <= ST_SUM;
        end
        ST_SUM: begin
          sum_q <= sum_d;
          st_q  <= ST_CONV;
        end
        default: begin
          res_q  <= fp_d;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/fp4_blk_dot_chk.sv
module fp4_blk_dot_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] result_o
);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_busy_fall_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_busy_two_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);

  p_start_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  p_result_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);

  p_ignore_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && $past(busy_o)) |=> !busy_o);

  p_no_nan_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o[30:23] == 8'hFF) |-> (result_o[22:0] == 23'h0));

  p_no_subnormal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o[30:23] == 8'h00) |-> (result_o == 32'h0));
endmodule

bind fp4_blk_dot fp4_blk_dot_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/fp4_blk_dot_tb.sv
module fp4_blk_dot_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [255:0] a_words_i = '0;
  logic [255:0] b_words_i = '0;
  logic [7:0]   scale_a_i = '0;
  logic [7:0]   scale_b_i = '0;
  logic         busy_o, done_o;
  logic [31:0]  result_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  fp4_blk_dot u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .a_words_i(a_words_i), .b_words_i(b_words_i),
    .scale_a_i(scale_a_i), .scale_b_i(scale_b_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  // {a byte fill, b byte fill, scale a, scale b, expected}
  localparam int NV = 17;
  localparam logic [63:0] VEC [NV] = '{
    {8'h08, 8'h08, 8'h7F, 8'h7F, 32'h42000000},  // R1 R3: 32 x 1*1
    {8'h08, 8'h08, 8'h82, 8'h7F, 32'h43800000},  // R4: A scale 8
    {8'h08, 8'h08, 8'h7F, 8'h81, 32'h43000000},  // R4: B scale 4
    {8'h1C, 8'h3C, 8'h7F, 8'h7F, 32'hC4900000},  // R1 R3: 6 * -6
    {8'h04, 8'h04, 8'h7F, 8'h7F, 32'h41000000},  // R1: 0.5 * 0.5
    {8'h14, 8'h0C, 8'h7F, 8'h7F, 32'h43100000},  // R1: 3 * 1.5
    {8'h18, 8'h30, 8'h7F, 8'h7F, 32'hC3800000},  // R1: 4 * -2
    {8'hCB, 8'h4B, 8'h7F, 8'h7F, 32'h42000000},  // R1: padding set
    {8'h00, 8'h1C, 8'h7F, 8'h7F, 32'h00000000},  // R5: zero
    {8'h20, 8'h08, 8'h7F, 8'h7F, 32'h00000000},  // R5: negative zero
    {8'h1C, 8'h1C, 8'hFF, 8'hFF, 32'h7F800000},  // R6: +inf
    {8'h3C, 8'h1C, 8'hFF, 8'hFF, 32'hFF800000},  // R6: -inf
    {8'h1C, 8'h1C, 8'hFF, 8'h74, 32'h7F100000},  // R6: largest in range
    {8'h1C, 8'h1C, 8'hFF, 8'h75, 32'h7F800000},  // R6: first overflow
    {8'h08, 8'h08, 8'h00, 8'h00, 32'h00000000},  // R7: deep underflow
    {8'h04, 8'h04, 8'h7D, 8'h00, 32'h00800000},  // R7: smallest normal
    {8'h04, 8'h04, 8'h7C, 8'h00, 32'h00000000}   // R7: just below normal
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // start at next posedge; verifies R8 timing and returns result at done
  task automatic run_op(input logic [255:0] a, input logic [255:0] b,
                        input logic [7:0] sa, input logic [7:0] sb,
                        output logic [31:0] res);
    @(negedge clk_i);
    a_words_i = a; b_words_i = b; scale_a_i = sa; scale_b_i = sb;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    a_words_i = ~a;  // sampled already; must not matter
    chk("R8 busy c1", {30'b0, busy_o, done_o}, 32'h2);
    @(negedge clk_i);
    chk("R8 busy c2", {30'b0, busy_o, done_o}, 32'h2);
    @(negedge clk_i);
    chk("R8 done", {30'b0, busy_o, done_o}, 32'h1);
    res = result_o;
    @(negedge clk_i);
    chk("R8 done drop", {30'b0, busy_o, done_o}, 32'h0);
    chk("R8 result hold", result_o, res);
  endtask

  initial begin
    logic [31:0] r;
    int dones;
    #1;
    chk("R10 reset busy/done", {30'b0, busy_o, done_o}, 32'h0);
    chk("R10 reset result", result_o, 32'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 idle after reset", {30'b0, busy_o, done_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      run_op({32{VEC[i][63:56]}}, {32{VEC[i][55:48]}}, VEC[i][47:40], VEC[i][39:32], r);
      chk($sformatf("R3 R4 R5 R6 R7 vector %0d", i), r, VEC[i][31:0]);
    end

    // R2: element 0 only, 6 * 2 = 12
    run_op(256'h1C, 256'h10, 8'h7F, 8'h7F, r);
    chk("R2 element 0", r, 32'h41400000);
    // R2: element 31 only, 1.5 * 1.5 = 2.25
    run_op({8'h0C, 248'h0}, {8'h0C, 248'h0}, 8'h7F, 8'h7F, r);
    chk("R2 element 31", r, 32'h40100000);
    // R2: different indices do not pair
    run_op(256'h08, 256'h0800, 8'h7F, 8'h7F, r);
    chk("R2 index pairing", r, 32'h00000000);
    // R5: alternating +1/-1 cancels exactly
    run_op({8{32'h28082808}}, {32{8'h08}}, 8'h7F, 8'h7F, r);
    chk("R5 cancel", r, 32'h00000000);
    // R3: mixed signs, 16*(1*1) + 16*(-6*1) = -80
    run_op({8{32'h3C083C08}}, {32{8'h08}}, 8'h7F, 8'h7F, r);
    chk("R3 mixed", r, 32'hC2A00000);

    // R9: start while busy is ignored
    @(negedge clk_i);
    a_words_i = {32{8'h08}}; b_words_i = {32{8'h08}};
    scale_a_i = 8'h7F; scale_b_i = 8'h7F; start_i = 1'b1;
    @(negedge clk_i);
    a_words_i = {32{8'h1C}}; b_words_i = {32{8'h1C}};  // start held high, busy
    dones = 0;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 4; c++) begin
      if (done_o) dones++;
      @(negedge clk_i);
    end
    chk("R9 single done", 32'(dones), 32'd1);
    chk("R9 first result kept", result_o, 32'h42000000);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule